// File: doc/BRIEF.md
# Sigma-Delta Phase Error Canceller

This block sits between the time-to-digital converter of a digital fractional-N synthesizer and its loop filter. The divider is dithered by a sigma-delta modulator. Every dither step leaves a known quantization error, and the running sum of that error appears as phase error in each TDC sample. The block keeps that running sum as a prediction. It scales the prediction by a learned gain and subtracts the result from the TDC sample, so the loop filter sees mostly the true phase error.

The gain is learned online. The residual after subtraction is correlated with the sign of the prediction. Each correlation term is right-shifted by a programmable step size and added into a saturating integrator. A one-pole low-pass filter then smooths the integrator to give the gain. Cancellation and learning run only while the lock controller asserts `cancel_en`, which it does in the steady-state lock phase. When `cancel_en` is low the gain is frozen and the TDC samples pass through unchanged. Only reset clears the learned gain.

Top module: `qn_canceller`

## Requirements
- R1: A synchronous active-low reset clears `err_out`, `err_valid` and `scale_q` to zero, and also clears the prediction and the integrator.
- R2: `err_valid` equals the `sample_valid` of the previous cycle. `err_out` changes only on the cycle after a cycle with `sample_valid` high, and holds its value otherwise.
- R3: On each valid sample the prediction becomes the previous prediction plus the sign-extended `quant_err`. The sample uses this updated value. The prediction advances whether or not `cancel_en` is high.
- R4: With `cancel_en` low, a valid sample gives `err_out = tdc_err` one cycle later.
- R5: With `cancel_en` high, a valid sample gives `err_out = tdc_err - ((scale_q*pred + 2^(G_FRAC-1)) >>> G_FRAC)` one cycle later. The result wraps to E_W bits. `scale_q` and `pred` are signed, `pred` is the updated prediction, and G_FRAC defaults to 12.
- R6: With `cancel_en` high, a valid sample adds `(s*r) >>> mu_shift` to the integrator, and the sum saturates to the signed G_W-bit range. Here r is the residual sent to `err_out`. s is +1 when the prediction is positive, -1 when it is negative, and 0 when it is zero.
- R7: On the same update, `scale_q` becomes `scale_q + ((I - scale_q) >>> LPF_SH)`, where I is the integrator value before this update. LPF_SH defaults to 2.
- R8: When `sample_valid` or `cancel_en` is low, `scale_q` and the integrator keep their values.
- R9: The prediction wraps in two's complement at P_W bits (default 12) and does not saturate.
- R10: When the TDC sample is exactly 0.75 times the prediction, `scale_q` settles near 0.75*2^G_FRAC = 3072. The residual power then ends at least 20 dB below the input power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | A new TDC sample and quantization error are present |
| cancel_en | input | 1 | Enables cancellation and gain learning (lock phase) |
| mu_shift | input | MU_W | Right-shift step size of the correlation term |
| tdc_err | input | E_W | Signed TDC phase error sample |
| quant_err | input | Q_W | Signed modulator quantization error for this sample |
| err_out | output | E_W | Signed corrected error sample |
| err_valid | output | 1 | `err_out` was updated this cycle |
| scale_q | output | G_W | Signed learned gain, G_FRAC fraction bits |

## Verification
A corrected sample and its valid flag appear exactly one clock after the edge that accepts the input sample. A correlation term reaches the integrator on that same edge, but it reaches `scale_q` only at the next valid update, so `scale_q` lags the residual by one sample. The bench drives inputs on the falling edge. It compares `err_out`, `err_valid` and `scale_q` 1 ns after the rising edge that consumes them, against a model built from the update equations above. Frozen-gain and passthrough cases are also checked at that same point, against the previously observed values.

// File: rtl/qnc_pkg.sv
// Shared types for the quantization noise canceller.
// Assumes: consumers size all data paths through their own parameters.
package qnc_pkg;

    // Three-way sign class of the phase prediction, used by the correlator.
    typedef enum logic [1:0] {
        SGN_ZERO = 2'd0,
        SGN_POS  = 2'd1,
        SGN_NEG  = 2'd2
    } sgn_e;

endpackage

// File: rtl/qnc_predictor.sv
// Phase prediction accumulator.
// Sums the sigma-delta quantization error once per valid sample. It offers
// the updated sum (previous sum plus the current error) combinationally,
// together with its sign class. It wraps in two's complement at P_W bits.
// Assumes: P_W >= Q_W.
module qnc_predictor
    import qnc_pkg::*;
#(
    parameter int Q_W = 8,
    parameter int P_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [Q_W-1:0]      quant_err,
    output logic signed [P_W-1:0] pred_now,
    output sgn_e                pred_sgn
);

    logic signed [P_W-1:0] sum_q;
    logic signed [P_W-1:0] q_ext;

    // Sign-extend the error to the prediction width.
    assign q_ext    = P_W'($signed(quant_err));
    // Updated prediction for this sample, wrapping on overflow.
    assign pred_now = sum_q + q_ext;

    // Classify the updated prediction for the sign-data correlator.
    always_comb begin
        if (pred_now == '0)
            pred_sgn = SGN_ZERO;
        else if (pred_now[P_W-1])
            pred_sgn = SGN_NEG;
        else
            pred_sgn = SGN_POS;
    end

    // Keep the running sum; advance only on valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_q <= '0;
        else if (sample_valid)
            sum_q <= pred_now;
    end

endmodule

// File: rtl/qnc_scaler.sv
// Scale, round and subtract stage.
// Multiplies the learned gain by the prediction and rounds half up at
// G_FRAC fraction bits. The product is subtracted from the TDC sample.
// The residual is offered combinationally to the gain loop, and the selected
// output is registered.
// Assumes: G_FRAC >= 1 and the rounded product fits E_W bits (it wraps).
module qnc_scaler #(
    parameter int E_W    = 16,
    parameter int P_W    = 12,
    parameter int G_W    = 16,
    parameter int G_FRAC = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_valid,
    input  logic                  cancel_en,
    input  logic signed [E_W-1:0] tdc_err,
    input  logic signed [P_W-1:0] pred,
    input  logic signed [G_W-1:0] scale,
    output logic signed [E_W-1:0] residual,
    output logic signed [E_W-1:0] err_out,
    output logic                  err_valid
);

    localparam int PROD_W = G_W + P_W;
    localparam logic signed [PROD_W:0] HALF = (PROD_W+1)'(1) <<< (G_FRAC - 1);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W:0]   prod_x;
    logic signed [PROD_W:0]   rounded;
    logic signed [PROD_W:0]   shifted;
    logic signed [E_W-1:0]    corr;
    logic signed [E_W-1:0]    sel;

    // Full-precision product of gain and prediction.
    assign prod     = scale * pred;
    // Widen by one bit so the rounding offset cannot overflow.
    assign prod_x   = (PROD_W+1)'(prod);
    // Round half up, then drop the fraction bits.
    assign rounded  = prod_x + HALF;
    assign shifted  = rounded >>> G_FRAC;
    assign corr     = E_W'(shifted);
    // Residual after cancellation, wrapping at E_W bits.
    assign residual = tdc_err - corr;
    // Choose cancelled or raw sample.
    assign sel      = cancel_en ? residual : tdc_err;

    // Register the output sample and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_out   <= '0;
            err_valid <= 1'b0;
        end else begin
            err_valid <= sample_valid;
            if (sample_valid)
                err_out <= sel;
        end
    end

endmodule

// File: rtl/qnc_gain_loop.sv
// Gain learning loop.
// A sign-data correlator multiplies the residual by the sign of the
// prediction and shifts it right by mu_shift. A saturating integrator sums
// these terms, and a one-pole low-pass filter (pole set by LPF_SH) turns the
// integrator into the gain. The filter reads the integrator value from
// before the current update. Both registers hold while update is low.
// Assumes: G_W >= 2, E_W >= 2.
module qnc_gain_loop
    import qnc_pkg::*;
#(
    parameter int E_W    = 16,
    parameter int G_W    = 16,
    parameter int MU_W   = 4,
    parameter int LPF_SH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  update,
    input  logic signed [E_W-1:0] residual,
    input  sgn_e                  pred_sgn,
    input  logic [MU_W-1:0]       mu_shift,
    output logic signed [G_W-1:0] scale_q,
    output logic signed [G_W-1:0] integ_q
);

    localparam int CW = E_W + 1;
    localparam int SW = ((G_W > CW) ? G_W : CW) + 1;
    localparam logic signed [SW-1:0] SMAX = SW'({1'b0, {(G_W-1){1'b1}}});
    localparam logic signed [SW-1:0] SMIN = ~SMAX;

    logic signed [CW-1:0]  r_x;
    logic signed [CW-1:0]  corr_v;
    logic signed [CW-1:0]  step_v;
    logic signed [SW-1:0]  sum_v;
    logic signed [G_W-1:0] integ_next;
    logic signed [G_W:0]   diff_v;
    logic signed [G_W:0]   lpf_v;
    logic signed [G_W-1:0] scale_next;

    // Widen the residual so that negating the most negative value is safe.
    assign r_x = CW'(residual);

    // Sign-data correlation of residual with prediction.
    always_comb begin
        unique case (pred_sgn)
            SGN_POS: corr_v = r_x;
            SGN_NEG: corr_v = -r_x;
            default: corr_v = '0;
        endcase
    end

    // Scale the correlation term by the step size.
    assign step_v = corr_v >>> mu_shift;
    assign sum_v  = SW'(integ_q) + SW'(step_v);

    // Clamp the integrator sum to the gain range.
    always_comb begin
        if (sum_v > SMAX)
            integ_next = G_W'(SMAX);
        else if (sum_v < SMIN)
            integ_next = G_W'(SMIN);
        else
            integ_next = G_W'(sum_v);
    end

    // One-pole smoothing of the integrator into the gain.
    assign diff_v     = (G_W+1)'(integ_q) - (G_W+1)'(scale_q);
    assign lpf_v      = diff_v >>> LPF_SH;
    assign scale_next = scale_q + G_W'(lpf_v);

    // Update integrator and gain only during cancellation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ_q <= '0;
            scale_q <= '0;
        end else if (update) begin
            integ_q <= integ_next;
            scale_q <= scale_next;
        end
    end

endmodule

// File: rtl/qn_canceller.sv
// Quantization noise canceller top.
// Chains the prediction accumulator, the scale-and-subtract stage and the
// gain learning loop. Cancellation and learning are gated by cancel_en,
// which is raised by the lock controller in the steady-state phase.
// Assumes: one sample per sample_valid pulse; all data are two's complement.
module qn_canceller
    import qnc_pkg::*;
#(
    parameter int E_W    = 16,
    parameter int Q_W    = 8,
    parameter int P_W    = 12,
    parameter int G_W    = 16,
    parameter int G_FRAC = 12,
    parameter int MU_W   = 4,
    parameter int LPF_SH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_valid,
    input  logic                  cancel_en,
    input  logic [MU_W-1:0]       mu_shift,
    input  logic signed [E_W-1:0] tdc_err,
    input  logic signed [Q_W-1:0] quant_err,
    output logic signed [E_W-1:0] err_out,
    output logic                  err_valid,
    output logic signed [G_W-1:0] scale_q
);

    logic signed [P_W-1:0] pred_w;
    sgn_e                  sgn_w;
    logic signed [E_W-1:0] resid_w;
    logic signed [G_W-1:0] integ_w;
    logic                  update_w;

    // Learning happens only on valid samples during lock.
    assign update_w = sample_valid & cancel_en;

    qnc_predictor #(
        .Q_W(Q_W),
        .P_W(P_W)
    ) u_pred (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_valid(sample_valid),
        .quant_err   (quant_err),
        .pred_now    (pred_w),
        .pred_sgn    (sgn_w)
    );

    qnc_scaler #(
        .E_W   (E_W),
        .P_W   (P_W),
        .G_W   (G_W),
        .G_FRAC(G_FRAC)
    ) u_scale (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_valid(sample_valid),
        .cancel_en   (cancel_en),
        .tdc_err     (tdc_err),
        .pred        (pred_w),
        .scale       (scale_q),
        .residual    (resid_w),
        .err_out     (err_out),
        .err_valid   (err_valid)
    );

    qnc_gain_loop #(
        .E_W   (E_W),
        .G_W   (G_W),
        .MU_W  (MU_W),
        .LPF_SH(LPF_SH)
    ) u_gain (
        .clk     (clk),
        .rst_n   (rst_n),
        .update  (update_w),
        .residual(resid_w),
        .pred_sgn(sgn_w),
        .mu_shift(mu_shift),
        .scale_q (scale_q),
        .integ_q (integ_w)
    );

endmodule

// File: rtl/qnc_checker.sv
// Temporal checks for qn_canceller, attached by bind.
// Assumes: the integrator value is brought in from the top's internal wire.
module qnc_checker #(
    parameter int E_W = 16,
    parameter int G_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sample_valid,
    input logic                  cancel_en,
    input logic signed [E_W-1:0] tdc_err,
    input logic signed [E_W-1:0] err_out,
    input logic                  err_valid,
    input logic signed [G_W-1:0] scale_q,
    input logic signed [G_W-1:0] integ
);

    logic                  arm_q;
    logic signed [G_W-1:0] g_prev;
    logic signed [G_W-1:0] i_prev;
    logic signed [G_W-1:0] lo;
    logic signed [G_W-1:0] hi;

    // Remember the state seen at an update so the step can be bounded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q  <= 1'b0;
            g_prev <= '0;
            i_prev <= '0;
        end else begin
            arm_q  <= sample_valid & cancel_en;
            g_prev <= scale_q;
            i_prev <= integ;
        end
    end

    // The gain must land between its old value and the old integrator.
    assign lo = (g_prev < i_prev) ? g_prev : i_prev;
    assign hi = (g_prev < i_prev) ? i_prev : g_prev;

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (err_out == '0 && !err_valid && scale_q == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> err_valid);

    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> !err_valid);

    a_r2_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(err_out));

    a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !cancel_en) |=> (err_out == $past(tdc_err)));

    a_r8_gain_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_valid && cancel_en) |=> $stable(scale_q));

    a_r7_gain_toward_integ: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |-> (scale_q >= lo && scale_q <= hi));

endmodule

bind qn_canceller qnc_checker #(
    .E_W(E_W),
    .G_W(G_W)
) u_qnc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .cancel_en   (cancel_en),
    .tdc_err     (tdc_err),
    .err_out     (err_out),
    .err_valid   (err_valid),
    .scale_q     (scale_q),
    .integ       (integ_w)
);

// File: tb/test_qn_canceller.sv
module test_qn_canceller;

    localparam int E_W = 16;
    localparam int Q_W = 8;
    localparam int P_W = 12;
    localparam int G_W = 16;
    localparam int GF  = 12;
    localparam int MUW = 4;
    localparam int LSH = 2;

    typedef struct packed {
        logic               v;
        logic               en;
        logic signed [15:0] e;
        logic signed [7:0]  q;
        logic signed [15:0] xe;
        logic               xv;
    } vec_t;

    // Right after reset the gain is zero, so every entry expects passthrough or hold.
    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 16'sd100,   8'sd1,  16'sd100,   1'b1},
        '{1'b0, 1'b0, 16'sd555,   8'sd5,  16'sd100,   1'b0},
        '{1'b1, 1'b0, -16'sd7,    -8'sd1, -16'sd7,    1'b1},
        '{1'b1, 1'b1, 16'sd300,   8'sd2,  16'sd300,   1'b1},
        '{1'b1, 1'b0, 16'sd32767, 8'sd0,  16'sd32767, 1'b1},
        '{1'b1, 1'b0, 16'sh8000,  8'sd0,  16'sh8000,  1'b1},
        '{1'b0, 1'b1, 16'sd1,     8'sd3,  16'sh8000,  1'b0},
        '{1'b1, 1'b0, 16'sd0,     8'sd0,  16'sd0,     1'b1}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  sample_valid = 1'b0;
    logic                  cancel_en = 1'b0;
    logic [MUW-1:0]        mu_shift = '0;
    logic signed [E_W-1:0] tdc_err = '0;
    logic signed [Q_W-1:0] quant_err = '0;
    logic signed [E_W-1:0] err_out;
    logic                  err_valid;
    logic signed [G_W-1:0] scale_q;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    longint m_p = 0, m_acc = 0, m_g = 0, m_out = 0;
    bit m_ov = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    qn_canceller #(
        .E_W(E_W), .Q_W(Q_W), .P_W(P_W), .G_W(G_W),
        .G_FRAC(GF), .MU_W(MUW), .LPF_SH(LSH)
    ) i_qn_canceller (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .cancel_en(cancel_en), .mu_shift(mu_shift), .tdc_err(tdc_err),
        .quant_err(quant_err), .err_out(err_out), .err_valid(err_valid),
        .scale_q(scale_q)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            failures++;
            $display("FAIL R2 watchdog actual=%0d expected<=200000", cyc);
            summary();
            $finish;
        end
    end

    function automatic longint wrapn(longint v, int w);
        longint m = longint'(1) << w;
        longint r = v % m;
        if (r < 0) r += m;
        if (r >= m / 2) r -= m;
        return r;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int next_q();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'(lfsr % 7) - 3;
    endfunction

    // Drive one cycle, advance the requirement model, wait until after the edge.
    task automatic drive(input bit v, input bit en, input longint e,
                         input longint q, input int mu);
        longint pn, corr, r, s, inc, a, gn;
        @(negedge clk);
        sample_valid = v;
        cancel_en    = en;
        tdc_err      = E_W'(e);
        quant_err    = Q_W'(q);
        mu_shift     = MUW'(mu);
        if (v) begin
            pn = wrapn(m_p + q, P_W);                         // R3, R9
            if (en) begin
                corr = (m_g * pn + (longint'(1) << (GF - 1))) >>> GF; // R5
                r = wrapn(e - corr, E_W);
                s = (pn > 0) ? 1 : ((pn < 0) ? -1 : 0);
                inc = (s * r) >>> mu;                         // R6
                a = m_acc + inc;
                if (a > 32767) a = 32767;
                if (a < -32768) a = -32768;
                gn = m_g + ((m_acc - m_g) >>> LSH);           // R7
                m_acc = a;
                m_g = gn;
            end else begin
                r = e;                                        // R4
            end
            m_out = r;
            m_p = pn;
        end
        m_ov = v;
        @(posedge clk);
        #1;
    endtask

    task automatic step_chk(input bit v, input bit en, input longint e,
                            input longint q, input int mu, input string tag);
        drive(v, en, e, q, mu);
        chk({tag, " err_out"}, longint'(err_out), m_out);
        chk({tag, " err_valid"}, longint'(err_valid), longint'(m_ov));
        chk({tag, " scale_q"}, longint'(scale_q), m_g);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sample_valid = 1'b0;
        cancel_en = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 err_out", longint'(err_out), 0);
        chk("R1 err_valid", longint'(err_valid), 0);
        chk("R1 scale_q", longint'(scale_q), 0);
        m_p = 0; m_acc = 0; m_g = 0; m_out = 0; m_ov = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        longint pw, ew, se, sr, g_hold;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 err_out at start", longint'(err_out), 0);
        chk("R1 scale_q at start", longint'(scale_q), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: passthrough (R4), hold and valid timing (R2), zero gain (R5).
        for (int i = 0; i < 8; i++) begin
            drive(VECS[i].v, VECS[i].en, longint'(VECS[i].e), longint'(VECS[i].q), 0);
            chk("R4/R2 table err_out", longint'(err_out), longint'(VECS[i].xe));
            chk("R2 table err_valid", longint'(err_valid), longint'(VECS[i].xv));
            chk("R8 table scale_q", longint'(scale_q), 0);
        end

        // R1: reset clears state that the table left behind.
        do_reset();

        // R10/R3/R5/R6/R7: learn a 0.75 gain from a random-walk prediction.
        se = 0; sr = 0;
        for (int i = 0; i < 1500; i++) begin
            pw = wrapn(m_p + next_q(), P_W);
            ew = (3 * pw + 2) >>> 2;
            lfsr = lfsr;
            drive(1, 1, ew, pw - m_p, 0);
            chk("R5 learn err_out", longint'(err_out), m_out);
            chk("R7 learn scale_q", longint'(scale_q), m_g);
            if (i >= 1244) begin
                se += ew * ew;
                sr += longint'(err_out) * longint'(err_out);
            end
        end
        checks++;
        if (scale_q < 2816 || scale_q > 3328) begin
            failures++;
            $display("FAIL R10 gain actual=%0d expected=3072+-256", scale_q);
        end
        checks++;
        if (sr * 100 > se) begin
            failures++;
            $display("FAIL R10 residual power actual=%0d expected<=%0d", sr * 100, se);
        end

        // R8: gain frozen while cancellation is off; samples pass through.
        g_hold = longint'(scale_q);
        for (int i = 0; i < 10; i++) begin
            drive(1, 0, 1000 + i, 1, 0);
            chk("R4 hold err_out", longint'(err_out), 1000 + i);
            chk("R8 hold scale_q", longint'(scale_q), g_hold);
        end
        drive(0, 1, 5, 0, 0);
        chk("R8 invalid scale_q", longint'(scale_q), g_hold);
        chk("R2 invalid err_out", longint'(err_out), 1009);

        // R9: push the prediction past its positive limit, then cancel with it.
        for (int i = 0; i < 20; i++) step_chk(1, 0, 0, 127, 0, "R9 push");
        for (int i = 0; i < 30; i++) step_chk(1, 1, 0, next_q(), 3, "R9 wrapped");

        // R6: integrator saturation with a large persistent residual.
        do_reset();
        step_chk(1, 1, 30000, 1, 0, "R6 sat");
        for (int i = 0; i < 39; i++) step_chk(1, 1, 30000, 0, 0, "R6 sat");
        checks++;
        if (scale_q < 30000) begin
            failures++;
            $display("FAIL R6 saturated gain actual=%0d expected>=30000", scale_q);
        end

        summary();
        $finish;
    end

endmodule